// File: doc/BRIEF.md
# Tag-Chained Quadword Source Channel

This block is the source side of a DMA channel. It reads 16-byte quadwords from memory and pushes them into a 128-word FIFO on the transmit side. Software loads four channel registers (control, payload address, quadword count and tag address) through a simple write port and then sets the enable bit. In block mode the channel moves the programmed number of quadwords and stops. In chain mode it fetches a 16-byte tag, moves the payload that tag describes, and then uses the tag's identifier to find the next tag. It keeps walking the chain until an end condition is met.

Each tag holds four 32-bit words. Word 0 carries a 16-bit quadword count in bits 15:0 and a 3-bit identifier in bits 30:28. Word 1 carries a pointer. Words 2 and 3 can be forwarded into the data stream.

The identifier sets two things: whether the payload sits right after the tag or at the pointer, and whether the next tag follows the payload, sits at the pointer, or sits right after the current tag. It also decides whether the chain ends after this tag's payload. The channel never writes into the FIFO unless the FIFO has room for the whole write. When the channel stops, it raises a one-cycle interrupt.

Top module: `qw_chain_walker`

## Requirements
- R1: After reset all four channel registers read zero, no memory read or FIFO write is issued, and `irq` is low.
- R2: In block mode (control bits 3:2 equal to zero) with enable (control bit 8) set, the channel reads `countReg` quadwords starting at `addrReg`. Each quadword is pushed as a four-word FIFO write. Each one raises the address by 16 and lowers the count by 1.
- R3: When the count is zero and either block mode is selected or the end flag is set, the channel clears control bit 8 and drops its end flag. `irq` is high for exactly the next cycle.
- R4: When a chain tag is loaded, the count becomes word 0 bits 15:0 and control bits 31:16 become word 0 bits 31:16. The identifier is word 0 bits 30:28.
- R5: Identifier 0 (ref-and-end) sets the address to word 1, advances the tag address by 16, and flags end.
- R6: Identifier 1 (continue) and identifier 7 (end) set the address to tag address + 16 and the next tag address to that address + count × 16. Identifier 7 also flags end.
- R7: Identifier 2 (jump) sets the address to tag address + 16 and the next tag address to word 1.
- R8: Identifiers 3 and 4 (ref) set the address to word 1 and advance the tag address by 16.
- R9: With control bit 6 set, each valid tag forwards its words 2 and 3 as a two-word FIFO write, with word 2 in bits 31:0. This write comes before that tag's payload.
- R10: A quadword write is made only when the FIFO has at least 4 free words, and a two-word tag write only when it has at least 2. The FIFO never holds more than its depth.
- R11: Identifiers 5 and 6 set control bit 9, clear bit 8 and raise `irq`. They cause no FIFO write and leave the address, count, tag address and control bits 31:16 unchanged.
- R12: At most one memory read is in flight. Read data is taken the cycle after `memRdEn`, with word 0 in bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 control, 1 address, 2 count, 3 tag address |
| regWdata | input | 32 | Register write data |
| ctrlReg | output | 32 | Control register value |
| addrReg | output | ADDR_W | Payload address |
| countReg | output | 16 | Remaining quadword count |
| tagAddrReg | output | ADDR_W | Next tag address |
| memRdEn | output | 1 | Memory read request |
| memRdAddr | output | ADDR_W | Memory read byte address |
| memRdData | input | 128 | Read quadword, valid one cycle after request |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrQuad | output | 1 | 1: four-word write, 0: two-word write in bits 63:0 |
| fifoWrData | output | 128 | FIFO write data |
| fifoLevel | input | LVL_W | Words currently held in the FIFO |
| irq | output | 1 | Completion/error interrupt pulse |

## Verification
A wrong next-tag pointer shows up on `memRdAddr` at the very next tag fetch, which happens one cycle after the count reaches zero. A wrong payload address shows up on the first read after a tag load. A lost or stray end flag shows at the ports within one cycle: either an extra tag fetch appears or the stop pulse comes too early. A behavioural model in the bench follows every clock and compares the read requests, FIFO writes, interrupt and all four registers. For that reason any divergence is reported in the cycle it first reaches a port, and the word stream drained from the FIFO is also compared against a list built from the chain layout.

// File: rtl/qw_chain_pkg.sv
package qw_chain_pkg;
  localparam int WORD_W = 32;
  localparam int QUAD_W = 128;
  localparam int CNT_W  = 16;

  localparam int CTRL_TTE = 6;
  localparam int CTRL_EN  = 8;
  localparam int CTRL_ERR = 9;

  typedef enum logic [2:0] {
    TAG_REFE = 3'd0,
    TAG_CNT  = 3'd1,
    TAG_NEXT = 3'd2,
    TAG_REF  = 3'd3,
    TAG_REFS = 3'd4,
    TAG_BAD5 = 3'd5,
    TAG_BAD6 = 3'd6,
    TAG_END  = 3'd7
  } tag_id_e;

  typedef struct packed {
    logic rdTag;
    logic ldData;
    logic ldTag;
    logic stop;
    logic setErr;
  } strobe_t;

  function automatic logic isBadId(input logic [2:0] id);
    return (id == TAG_BAD5) || (id == TAG_BAD6);
  endfunction
endpackage

// File: rtl/qw_chain_dp.sv
module qw_chain_dp
  import qw_chain_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [1:0]          regSel,
  input  logic [WORD_W-1:0]   regWdata,
  input  strobe_t             stb,
  input  logic [63:0]         tagLow,
  output logic [WORD_W-1:0]   ctrlReg,
  output logic [ADDR_W-1:0]   addrReg,
  output logic [CNT_W-1:0]    countReg,
  output logic [ADDR_W-1:0]   tagAddrReg,
  output logic                endFlag,
  output logic [ADDR_W-1:0]   memRdAddr
);
  localparam logic [ADDR_W-1:0] QBYTES = ADDR_W'(16);

  logic [WORD_W-1:0] w0, w1;
  tag_id_e           tagId;
  logic [ADDR_W-1:0] afterTag, payBytes;

  assign w0       = tagLow[31:0];
  assign w1       = tagLow[63:32];
  assign tagId    = tag_id_e'(w0[30:28]);
  assign afterTag = tagAddrReg + QBYTES;
  assign payBytes = ADDR_W'(w0[CNT_W-1:0]) << 4;
  assign memRdAddr = stb.rdTag ? tagAddrReg : addrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      addrReg    <= '0;
      countReg   <= '0;
      tagAddrReg <= '0;
      endFlag    <= 1'b0;
    end else begin
      if (stb.ldData) begin
        addrReg  <= addrReg + QBYTES;
        countReg <= countReg - CNT_W'(1);
      end
      if (stb.ldTag) begin
        ctrlReg[31:16] <= w0[31:16];
        countReg       <= w0[CNT_W-1:0];
        case (tagId)
          TAG_REFE: begin
            addrReg    <= ADDR_W'(w1);
            tagAddrReg <= afterTag;
            endFlag    <= 1'b1;
          end
          TAG_CNT, TAG_END: begin
            addrReg    <= afterTag;
            tagAddrReg <= afterTag + payBytes;
            if (tagId == TAG_END) endFlag <= 1'b1;
          end
          TAG_NEXT: begin
            addrReg    <= afterTag;
            tagAddrReg <= ADDR_W'(w1);
          end
          TAG_REF, TAG_REFS: begin
            addrReg    <= ADDR_W'(w1);
            tagAddrReg <= afterTag;
          end
          default: ;
        endcase
      end
      if (stb.stop) begin
        ctrlReg[CTRL_EN] <= 1'b0;
        endFlag          <= 1'b0;
      end
      if (stb.setErr) begin
        ctrlReg[CTRL_ERR] <= 1'b1;
        ctrlReg[CTRL_EN]  <= 1'b0;
        endFlag           <= 1'b0;
      end
      if (regWe) begin
        case (regSel)
          2'd0: ctrlReg    <= regWdata;
          2'd1: addrReg    <= ADDR_W'(regWdata);
          2'd2: countReg   <= regWdata[CNT_W-1:0];
          default: tagAddrReg <= ADDR_W'(regWdata);
        endcase
      end
    end
  end

  // R2: every payload beat lowers the count by one
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldData && !regWe) |=> (countReg == $past(countReg) - CNT_W'(1)));

  // R5: a ref-and-end tag leaves the end flag raised
  a_r5_refe_end: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldTag && tagId == TAG_REFE && !regWe) |=> endFlag);
endmodule

// File: rtl/qw_chain_ctrl.sv
module qw_chain_ctrl
  import qw_chain_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanEn,
  input  logic              chainMode,
  input  logic              tagXfer,
  input  logic              countZero,
  input  logic              endFlag,
  input  logic [QUAD_W-1:0] memRdData,
  input  logic [LVL_W-1:0]  fifoLevel,
  output strobe_t           stb,
  output logic              memRdEn,
  output logic              fifoWrEn,
  output logic              fifoWrQuad,
  output logic [QUAD_W-1:0] fifoWrData,
  output logic              irq
);
  typedef enum logic [1:0] {ST_RUN, ST_DWAIT, ST_TWAIT} state_e;

  state_e          state, nextState;
  logic [LVL_W:0]  freeWords;
  logic            badTag;

  assign freeWords = (LVL_W+1)'(FIFO_DEPTH) - {1'b0, fifoLevel};
  assign badTag    = isBadId(memRdData[30:28]);

  always_comb begin
    stb        = '0;
    memRdEn    = 1'b0;
    fifoWrEn   = 1'b0;
    fifoWrQuad = 1'b0;
    fifoWrData = memRdData;
    nextState  = state;
    case (state)
      ST_RUN: begin
        if (chanEn) begin
          if (!countZero) begin
            if (freeWords >= (LVL_W+1)'(4)) begin
              memRdEn   = 1'b1;
              nextState = ST_DWAIT;
            end
          end else if (!chainMode || endFlag) begin
            stb.stop = 1'b1;
          end else if (!tagXfer || freeWords >= (LVL_W+1)'(2)) begin
            memRdEn   = 1'b1;
            stb.rdTag = 1'b1;
            nextState = ST_TWAIT;
          end
        end
      end
      ST_DWAIT: begin
        fifoWrEn   = 1'b1;
        fifoWrQuad = 1'b1;
        stb.ldData = 1'b1;
        nextState  = ST_RUN;
      end
      default: begin
        fifoWrData = {64'b0, memRdData[127:64]};
        if (badTag) begin
          stb.setErr = 1'b1;
        end else begin
          stb.ldTag = 1'b1;
          fifoWrEn  = tagXfer;
        end
        nextState = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
      irq   <= 1'b0;
    end else begin
      state <= nextState;
      irq   <= stb.stop | stb.setErr;
    end
  end

  // R10: a write never exceeds the room left in the FIFO
  a_r10_fifo_room: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> (int'(fifoLevel) + (fifoWrQuad ? 4 : 2) <= FIFO_DEPTH));

  // R3: the interrupt is a single-cycle pulse
  a_r3_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R3: the interrupt coincides with a disabled channel
  a_r3_irq_disabled: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !chanEn);

  // R12: no second read while one is in flight
  a_r12_single_read: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);
endmodule

// File: rtl/qw_chain_walker.sv
module qw_chain_walker
  import qw_chain_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 128,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [31:0]       regWdata,
  output logic [31:0]       ctrlReg,
  output logic [ADDR_W-1:0] addrReg,
  output logic [15:0]       countReg,
  output logic [ADDR_W-1:0] tagAddrReg,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [127:0]      memRdData,
  output logic              fifoWrEn,
  output logic              fifoWrQuad,
  output logic [127:0]      fifoWrData,
  input  logic [LVL_W-1:0]  fifoLevel,
  output logic              irq
);
  strobe_t stb;
  logic    endFlag;

  qw_chain_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .stb(stb), .tagLow(memRdData[63:0]), .ctrlReg(ctrlReg), .addrReg(addrReg),
    .countReg(countReg), .tagAddrReg(tagAddrReg), .endFlag(endFlag),
    .memRdAddr(memRdAddr)
  );

  qw_chain_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .chanEn(ctrlReg[CTRL_EN]),
    .chainMode(ctrlReg[3:2] != 2'b00), .tagXfer(ctrlReg[CTRL_TTE]),
    .countZero(countReg == '0), .endFlag(endFlag), .memRdData(memRdData),
    .fifoLevel(fifoLevel), .stb(stb), .memRdEn(memRdEn), .fifoWrEn(fifoWrEn),
    .fifoWrQuad(fifoWrQuad), .fifoWrData(fifoWrData), .irq(irq)
  );
endmodule

// File: tb/qw_chain_walker_tb.sv
module qw_chain_walker_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regSel = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] ctrlReg, addrReg, tagAddrReg, memRdAddr;
  logic [15:0] countReg;
  logic memRdEn, fifoWrEn, fifoWrQuad, irq;
  logic [127:0] memRdData = '0;
  logic [127:0] fifoWrData;
  logic [7:0] fifoLevel = '0;

  always #2.5 clk = ~clk;

  qw_chain_walker dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .ctrlReg(ctrlReg), .addrReg(addrReg), .countReg(countReg), .tagAddrReg(tagAddrReg),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .fifoWrEn(fifoWrEn), .fifoWrQuad(fifoWrQuad), .fifoWrData(fifoWrData),
    .fifoLevel(fifoLevel), .irq(irq)
  );

  int total = 0, bad = 0, cycles = 0, irqSeen = 0;
  bit finished = 0;
  bit drainEn = 1;
  string curReq = "R1";

  logic [127:0] tagMem [int unsigned];
  logic [31:0] fifoQ[$], gotQ[$], expQ[$];

  function automatic logic [31:0] pat(input logic [31:0] a, input int k);
    return (a + 32'(4 * k)) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [127:0] quadAt(input logic [31:0] a);
    if (tagMem.exists(a)) return tagMem[a];
    return {pat(a, 3), pat(a, 2), pat(a, 1), pat(a, 0)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory: one-cycle read latency
  always @(posedge clk) if (memRdEn) memRdData <= quadAt(memRdAddr);

  // FIFO and consumer
  always @(posedge clk) begin
    if (!rstN) begin
      fifoQ.delete();
      fifoLevel <= '0;
    end else begin
      int had;
      had = fifoQ.size();
      if (fifoWrEn) begin
        fifoQ.push_back(fifoWrData[31:0]);
        fifoQ.push_back(fifoWrData[63:32]);
        if (fifoWrQuad) begin
          fifoQ.push_back(fifoWrData[95:64]);
          fifoQ.push_back(fifoWrData[127:96]);
        end
      end
      if (drainEn && had > 0) gotQ.push_back(fifoQ.pop_front());
      if (fifoQ.size() > 128) begin
        total++; bad++;
        $display("FAIL R10 fifo overflow actual=%0d expected<=128", fifoQ.size());
      end
      fifoLevel <= 8'(fifoQ.size());
    end
  end

  // behavioural reference model
  int mState = 0;
  logic [31:0] mCtrl = 0, mAddr = 0, mTag = 0, mPend = 0;
  logic [15:0] mCnt = 0;
  bit mEnd = 0, mIrq = 0;
  bit eRdEn = 0, eTagRd = 0, eStop = 0, eErr = 0, eWr = 0, eQuad = 0;
  logic [31:0] eRdAddr = 0;
  logic [127:0] eData = 0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [127:0] d;
      int freeW;
      freeW = 128 - int'(fifoLevel);
      d = quadAt(mPend);
      eRdEn = 0; eTagRd = 0; eStop = 0; eErr = 0; eWr = 0; eQuad = 0; eData = '0;
      case (mState)
        0: if (mCtrl[8]) begin
             if (mCnt != 0) begin
               if (freeW >= 4) eRdEn = 1;
             end else if (mCtrl[3:2] == 0 || mEnd) eStop = 1;
             else if (!mCtrl[6] || freeW >= 2) begin eRdEn = 1; eTagRd = 1; end
           end
        1: begin eWr = 1; eQuad = 1; eData = d; end
        default: if (d[30:28] == 5 || d[30:28] == 6) eErr = 1;
                 else if (mCtrl[6]) begin eWr = 1; eData = {64'b0, d[127:64]}; end
      endcase
      eRdAddr = eTagRd ? mTag : mAddr;
      check(memRdEn === eRdEn && (!eRdEn || memRdAddr === eRdAddr), curReq,
            "read request", {memRdEn, memRdAddr}, {eRdEn, eRdAddr});
      check(fifoWrEn === eWr && (!eWr || (fifoWrQuad === eQuad && fifoWrData === eData)),
            curReq, "fifo write", fifoWrData, eData);
      check(irq === mIrq, curReq, "irq", irq, mIrq);
      check(ctrlReg === mCtrl && addrReg === mAddr && countReg === mCnt && tagAddrReg === mTag,
            curReq, "registers", {ctrlReg, addrReg, countReg, tagAddrReg},
            {mCtrl, mAddr, mCnt, mTag});
      if (irq === 1'b1) irqSeen++;
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCtrl = 0; mAddr = 0; mTag = 0; mCnt = 0; mEnd = 0; mIrq = 0; mPend = 0;
    end else begin
      logic [127:0] d;
      d = quadAt(mPend);
      mIrq = eStop | eErr;
      if (mState == 1) begin mAddr = mAddr + 16; mCnt = mCnt - 1; end
      if (mState == 2 && !eErr) begin
        logic [31:0] w0, w1, nextTag;
        w0 = d[31:0]; w1 = d[63:32];
        mCtrl[31:16] = w0[31:16];
        mCnt = w0[15:0];
        nextTag = mTag + 16;
        case (w0[30:28])
          0: begin mAddr = w1; mTag = nextTag; mEnd = 1; end
          1, 7: begin mAddr = nextTag; mTag = nextTag + 32'(w0[15:0]) * 16;
                      if (w0[30:28] == 7) mEnd = 1; end
          2: begin mAddr = nextTag; mTag = w1; end
          default: begin mAddr = w1; mTag = nextTag; end
        endcase
      end
      if (eStop) begin mCtrl[8] = 0; mEnd = 0; end
      if (eErr) begin mCtrl[9] = 1; mCtrl[8] = 0; mEnd = 0; end
      if (regWe) case (regSel)
        0: mCtrl = regWdata;
        1: mAddr = regWdata;
        2: mCnt = regWdata[15:0];
        default: mTag = regWdata;
      endcase
      if (eRdEn) begin mPend = eRdAddr; mState = eTagRd ? 2 : 1; end
      else mState = 0;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] data);
    @(posedge clk); #1;
    regWe = 1; regSel = sel; regWdata = data;
    @(posedge clk); #1;
    regWe = 0;
  endtask

  task automatic expQuad(input logic [31:0] a);
    for (int k = 0; k < 4; k++) expQ.push_back(pat(a, k));
  endtask

  function automatic logic [127:0] mkTag(input int id, input logic [15:0] cnt,
      input logic [31:0] w1, input logic [31:0] w2, input logic [31:0] w3);
    logic [31:0] w0;
    w0 = {1'b0, 3'(id), 12'hABC, cnt};
    return {w3, w2, w1, w0};
  endfunction

  task automatic finishRun(input string req, input int irqExp);
    int n = 0;
    @(negedge clk);
    while (ctrlReg[8] === 1'b1 && n < 3000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    n = 0;
    while (fifoLevel != 0 && n < 3000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    begin
      bit ok = (gotQ.size() == expQ.size());
      for (int i = 0; i < gotQ.size() && ok; i++) if (gotQ[i] !== expQ[i]) ok = 0;
      check(ok, req, "word stream (size)", 128'(gotQ.size()), 128'(expQ.size()));
    end
    check(irqSeen == irqExp, req, "irq pulse count", 128'(irqSeen), 128'(irqExp));
    gotQ.delete(); expQ.delete(); irqSeen = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1: reset state
    check(ctrlReg == 0 && addrReg == 0 && countReg == 0 && tagAddrReg == 0 && !irq
          && !memRdEn && !fifoWrEn, "R1", "reset state", {ctrlReg, addrReg}, '0);

    // R2 / R3: block mode, 3 quadwords then stop
    curReq = "R2";
    regWrite(1, 32'h1000); regWrite(2, 3); regWrite(0, 32'h100);
    expQuad(32'h1000); expQuad(32'h1010); expQuad(32'h1020);
    finishRun("R2", 1);
    check(addrReg == 32'h1030 && countReg == 0 && ctrlReg == 0, "R3", "block stop regs",
          {addrReg, countReg, ctrlReg}, {32'h1030, 16'h0, 32'h0});

    // R3: block mode with zero count stops at once
    curReq = "R3";
    regWrite(0, 32'h100);
    finishRun("R3", 1);

    // R4 R6 R7 R8: mixed chain
    curReq = "R7";
    tagMem[32'h2000] = mkTag(1, 2, 0, 0, 0);
    tagMem[32'h2030] = mkTag(2, 1, 32'h3000, 0, 0);
    tagMem[32'h3000] = mkTag(3, 2, 32'h8000, 0, 0);
    tagMem[32'h3010] = mkTag(4, 1, 32'h9000, 0, 0);
    tagMem[32'h3020] = mkTag(7, 1, 0, 0, 0);
    expQuad(32'h2010); expQuad(32'h2020); expQuad(32'h2040);
    expQuad(32'h8000); expQuad(32'h8010); expQuad(32'h9000); expQuad(32'h3030);
    regWrite(3, 32'h2000); regWrite(0, 32'h104);
    finishRun("R8", 1);
    check(tagAddrReg == 32'h3040 && addrReg == 32'h3040, "R6", "end tag links",
          {tagAddrReg, addrReg}, {32'h3040, 32'h3040});
    check(ctrlReg == 32'h7ABC_0004, "R4", "control upper copy", ctrlReg, 32'h7ABC_0004);

    // R5: ref-and-end
    curReq = "R5";
    tagMem[32'h4000] = mkTag(0, 2, 32'hA000, 0, 0);
    expQuad(32'hA000); expQuad(32'hA010);
    regWrite(3, 32'h4000); regWrite(0, 32'h104);
    finishRun("R5", 1);
    check(tagAddrReg == 32'h4010 && addrReg == 32'hA020, "R5", "refe regs",
          {tagAddrReg, addrReg}, {32'h4010, 32'hA020});

    // R9: tag words forwarded
    curReq = "R9";
    tagMem[32'h5000] = mkTag(1, 1, 0, 32'h1111_1111, 32'h2222_2222);
    tagMem[32'h5020] = mkTag(7, 0, 0, 32'h3333_3333, 32'h4444_4444);
    expQ.push_back(32'h1111_1111); expQ.push_back(32'h2222_2222);
    expQuad(32'h5010);
    expQ.push_back(32'h3333_3333); expQ.push_back(32'h4444_4444);
    regWrite(3, 32'h5000); regWrite(0, 32'h144);
    finishRun("R9", 1);

    // R11: invalid identifiers 5 and 6
    curReq = "R11";
    tagMem[32'h6000] = mkTag(5, 3, 32'hDEAD, 0, 0);
    tagMem[32'h6100] = mkTag(6, 3, 32'hDEAD, 0, 0);
    regWrite(1, 32'h0); regWrite(2, 0);
    regWrite(3, 32'h6000); regWrite(0, 32'h104);
    finishRun("R11", 1);
    check(ctrlReg == 32'h204 && tagAddrReg == 32'h6000 && countReg == 0 && addrReg == 0,
          "R11", "id 5 error state", {ctrlReg, tagAddrReg}, {32'h204, 32'h6000});
    regWrite(3, 32'h6100); regWrite(0, 32'h104);
    finishRun("R11", 1);
    check(ctrlReg == 32'h204 && tagAddrReg == 32'h6100, "R11", "id 6 error state",
          {ctrlReg, tagAddrReg}, {32'h204, 32'h6100});

    // R10 / R12: backpressure with consumer stopped
    curReq = "R10";
    drainEn = 0;
    regWrite(1, 32'hC000); regWrite(2, 40); regWrite(0, 32'h100);
    repeat (200) @(negedge clk);
    check(fifoLevel == 128 && countReg == 8, "R10", "stall when full",
          {fifoLevel, countReg}, {8'd128, 16'd8});
    for (int i = 0; i < 40; i++) expQuad(32'hC000 + 32'(16 * i));
    drainEn = 1;
    curReq = "R12";
    finishRun("R12", 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule